// File: doc/BRIEF.md
# Exclusive Last-Level Cache Policy Controller

This block keeps the replacement and presence state of a shared last-level cache that holds no line also held in the private L2 above it. For every line it stores the tag, a valid flag, a dirty flag and a 2-bit re-reference prediction value (RRPV). It handles three kinds of event: lookups caused by L2 read misses, lines that the L2 evicts and offers for installation, and fills that return from memory. Data arrays and coherence tracking are kept elsewhere.

Because the cache is exclusive, a line leaves it on a lookup hit, and lines that come from memory go directly to the L2. The cache therefore has no reuse history of its own. Each line sent up to the L2 carries an origin bit: 1 when this cache supplied it and 0 when memory did. When the L2 evicts the line, the bit comes back with it and chooses the RRPV at which the line is installed. A dirty line displaced by an install produces a writeback request.

Events arrive one per cycle on a valid/ready handshake and complete in the cycle they are accepted. An event is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` falls only while a writeback is waiting and `wb_ready` is low. The writeback port is valid/ready. `wb_valid` and `wb_addr` stay fixed until the consumer takes them. The response port has no back-pressure: `rsp_valid` pulses for one cycle, one cycle after a lookup or fill is accepted.

Top module: `llc_excl_ctrl`

## Requirements
- R1: A lookup (req_kind 0) that hits gives, one cycle later, rsp_valid=1, rsp_hit=1, rsp_sfl=1 and rsp_dirty equal to the stored dirty flag. The line is invalidated, so a second lookup of the same address misses.
- R2: A lookup that misses gives rsp_valid=1, rsp_hit=0, rsp_sfl=0 and rsp_dirty=0, and leaves the stored state unchanged.
- R3: A fill (req_kind 2) gives rsp_valid=1, rsp_hit=0, rsp_sfl=0. It allocates nothing, so a later lookup of that address misses.
- R4: An install (req_kind 1) with req_sfl=0 places the line at RRPV 2.
- R5: An install with req_sfl=1 places the line at RRPV 0.
- R6: An install first takes the lowest-numbered invalid way in its set. It evicts nothing and ages no way.
- R7: When every way is valid, the victim is the lowest-numbered way at RRPV 3. If no way is at 3, all ways in the set are first aged by the amount that brings the largest RRPV to 3.
- R8: The installed line keeps req_dirty as its dirty flag, and a later hit reports that flag on rsp_dirty.
- R9: A dirty victim raises wb_valid one cycle after the install, with wb_addr = {victim tag, set index, zero offset}. A clean victim raises nothing.
- R10: While wb_valid=1 and wb_ready=0, req_ready is 0 and wb_addr holds steady. No event is accepted.
- R11: In the cycle a pending writeback is taken, a new install that evicts a dirty line is accepted, and wb_addr moves straight to the new victim's address.
- R12: An install whose tag is already present updates that way in place. It ORs in req_dirty and sets the RRPV from req_sfl, so only one copy is ever held.
- R13: After reset, req_ready=1, rsp_valid=0, wb_valid=0, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Event offered |
| req_ready | output | 1 | Event can be accepted |
| req_kind | input | 2 | 0 lookup, 1 install, 2 fill, 3 ignored |
| req_addr | input | ADDR_W | Line address |
| req_sfl | input | 1 | Origin bit of an installed line |
| req_dirty | input | 1 | Dirty flag of an installed line |
| rsp_valid | output | 1 | Lookup or fill response |
| rsp_hit | output | 1 | Lookup hit |
| rsp_sfl | output | 1 | Origin bit for the line sent to L2 |
| rsp_dirty | output | 1 | Dirty flag of the line taken on a hit |
| wb_valid | output | 1 | Writeback request pending |
| wb_ready | input | 1 | Writeback consumer ready |
| wb_addr | output | ADDR_W | Line address to write back |

## Verification
A new install that displaces a dirty line can be accepted in the same cycle as the handoff of an earlier writeback. The bench provokes this by holding `wb_ready` low after a first dirty eviction while it offers a second install that will also evict a dirty line. It checks that the request stalls and that the first address holds steady. It then raises `wb_ready` and checks that, on the very next edge, `wb_addr` turns to the second victim's address with no bubble and no lost request. The RRIP ordering is checked through which lines survive a series of installs into one set whose ways carry both origin values.

// File: rtl/llc_excl_pkg.sv
package llc_excl_pkg;
  typedef enum logic [1:0] {
    EV_LOOKUP  = 2'd0,
    EV_INSTALL = 2'd1,
    EV_FILL    = 2'd2,
    EV_NONE    = 2'd3
  } llc_ev_e;

  localparam int RRPV_W = 2;
  localparam logic [RRPV_W-1:0] RRPV_NEAR  = 2'd0;
  localparam logic [RRPV_W-1:0] RRPV_FAR   = 2'd2;
  localparam logic [RRPV_W-1:0] RRPV_EVICT = 2'd3;
endpackage

// File: rtl/llc_set_store.sv
module llc_set_store
  import llc_excl_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [IDX_W-1:0]                  rd_set,
  output logic [WAYS-1:0]                   rd_valid,
  output logic [WAYS-1:0]                   rd_dirty,
  output logic [WAYS-1:0][RRPV_W-1:0]       rd_rrpv,
  output logic [WAYS-1:0][TAG_W-1:0]        rd_tag,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_set,
  input  logic [WAYS-1:0]                   wr_valid,
  input  logic [WAYS-1:0]                   wr_dirty,
  input  logic [WAYS-1:0][RRPV_W-1:0]       wr_rrpv,
  input  logic [WAYS-1:0][TAG_W-1:0]        wr_tag
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [RRPV_W-1:0] rrpv_q [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid_q <= '0;
      else if (wr_en) valid_q[wr_set] <= wr_valid[w];
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        dirty_q[wr_set] <= wr_dirty[w];
        rrpv_q[wr_set]  <= wr_rrpv[w];
        tag_q[wr_set]   <= wr_tag[w];
      end
    end

    assign rd_valid[w] = valid_q[rd_set];
    assign rd_dirty[w] = dirty_q[rd_set];
    assign rd_rrpv[w]  = rrpv_q[rd_set];
    assign rd_tag[w]   = tag_q[rd_set];
  end
endmodule

// File: rtl/llc_victim_pick.sv
module llc_victim_pick
  import llc_excl_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][RRPV_W-1:0] rrpv_i,
  output logic [WAY_W-1:0]            way_o,
  output logic [WAYS-1:0][RRPV_W-1:0] aged_o
);
  logic              any_free;
  logic [RRPV_W-1:0] top_rrpv;
  logic [RRPV_W-1:0] bump;

  always_comb begin
    any_free = ~&valid_i;
    top_rrpv = '0;
    for (int w = 0; w < WAYS; w++)
      if (rrpv_i[w] > top_rrpv) top_rrpv = rrpv_i[w];
    bump = any_free ? '0 : (RRPV_EVICT - top_rrpv);
    for (int w = 0; w < WAYS; w++)
      aged_o[w] = rrpv_i[w] + bump;
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (any_free ? !valid_i[w] : (aged_o[w] == RRPV_EVICT))
        way_o = WAY_W'(w);
    end
  end

  always_comb begin
    if (any_free) begin
      // R6
      free_way_first_chk: assert (!valid_i[way_o]);
    end else begin
      // R7
      evict_at_max_chk: assert (aged_o[way_o] == RRPV_EVICT);
    end
  end
endmodule

// File: rtl/llc_wb_slot.sv
module llc_wb_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(addr_o));

  // R11
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (!valid_o || ready_i));
endmodule

// File: rtl/llc_excl_ctrl.sv
module llc_excl_ctrl
  import llc_excl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_sfl,
  input  logic              req_dirty,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_sfl,
  output logic              rsp_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  llc_ev_e          kind;
  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] tag_in;
  logic             fire;

  assign kind    = llc_ev_e'(req_kind);
  assign set_idx = req_addr[OFF_W +: IDX_W];
  assign tag_in  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_ready = !wb_valid || wb_ready;
  assign fire    = req_valid && req_ready;

  logic [WAYS-1:0]              cur_valid, cur_dirty;
  logic [WAYS-1:0][RRPV_W-1:0]  cur_rrpv, aged_rrpv;
  logic [WAYS-1:0][TAG_W-1:0]   cur_tag;
  logic [WAYS-1:0]              nxt_valid, nxt_dirty;
  logic [WAYS-1:0][RRPV_W-1:0]  nxt_rrpv;
  logic [WAYS-1:0][TAG_W-1:0]   nxt_tag;
  logic                         wr_en;
  logic [WAY_W-1:0]             pick_way;

  llc_set_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) store_i (
    .clk(clk), .rst_n(rst_n), .rd_set(set_idx),
    .rd_valid(cur_valid), .rd_dirty(cur_dirty), .rd_rrpv(cur_rrpv), .rd_tag(cur_tag),
    .wr_en(wr_en), .wr_set(set_idx),
    .wr_valid(nxt_valid), .wr_dirty(nxt_dirty), .wr_rrpv(nxt_rrpv), .wr_tag(nxt_tag)
  );

  llc_victim_pick #(.WAYS(WAYS)) pick_i (
    .valid_i(cur_valid), .rrpv_i(cur_rrpv), .way_o(pick_way), .aged_o(aged_rrpv)
  );

  logic [WAYS-1:0] hit_vec;
  logic            hit_any;
  logic [WAY_W-1:0] hit_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = cur_valid[w] && (cur_tag[w] == tag_in);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end
  assign hit_any = |hit_vec;

  logic [RRPV_W-1:0] ins_rrpv;
  logic              wb_load;
  logic [ADDR_W-1:0] wb_addr_nxt;

  assign ins_rrpv = req_sfl ? RRPV_NEAR : RRPV_FAR;

  always_comb begin
    nxt_valid   = cur_valid;
    nxt_dirty   = cur_dirty;
    nxt_rrpv    = cur_rrpv;
    nxt_tag     = cur_tag;
    wr_en       = 1'b0;
    wb_load     = 1'b0;
    wb_addr_nxt = {cur_tag[pick_way], set_idx, {OFF_W{1'b0}}};
    unique case (kind)
      EV_LOOKUP: begin
        if (hit_any) begin
          nxt_valid[hit_way] = 1'b0;
          wr_en = fire;
        end
      end
      EV_INSTALL: begin
        wr_en = fire;
        if (hit_any) begin
          nxt_dirty[hit_way] = cur_dirty[hit_way] | req_dirty;
          nxt_rrpv[hit_way]  = ins_rrpv;
        end else begin
          nxt_rrpv            = aged_rrpv;
          wb_load             = fire && cur_valid[pick_way] && cur_dirty[pick_way];
          nxt_valid[pick_way] = 1'b1;
          nxt_dirty[pick_way] = req_dirty;
          nxt_rrpv[pick_way]  = ins_rrpv;
          nxt_tag[pick_way]   = tag_in;
        end
      end
      default: ;
    endcase
  end

  llc_wb_slot #(.ADDR_W(ADDR_W)) wb_i (
    .clk(clk), .rst_n(rst_n), .load_i(wb_load), .addr_i(wb_addr_nxt),
    .ready_i(wb_ready), .valid_o(wb_valid), .addr_o(wb_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_sfl   <= 1'b0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= fire && (kind == EV_LOOKUP || kind == EV_FILL);
      rsp_hit   <= (kind == EV_LOOKUP) && hit_any;
      rsp_sfl   <= (kind == EV_LOOKUP) && hit_any;
      rsp_dirty <= (kind == EV_LOOKUP) && hit_any && cur_dirty[hit_way];
    end
  end

  // R12
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R1
  hit_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && kind == EV_LOOKUP && hit_any |=> rsp_valid && rsp_sfl);

  // R2
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !rsp_sfl && !rsp_dirty);

  // R3
  fill_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && kind == EV_FILL |-> !wr_en);
endmodule

// File: tb/llc_excl_ctrl_tb_top.sv
`timescale 1ns/1ps
module llc_excl_ctrl_tb_top;
  localparam logic [1:0] K_LOOK = 2'd0, K_INST = 2'd1, K_FILL = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [31:0] req_addr = '0;
  logic        req_sfl = 1'b0;
  logic        req_dirty = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_sfl, rsp_dirty;
  logic        wb_valid;
  logic        wb_ready = 1'b1;
  logic [31:0] wb_addr;

  int checks = 0;
  int fails  = 0;
  logic        c_rv, c_rh, c_rs, c_rd, c_wv;
  logic [31:0] c_wa;

  always #2.5 clk = ~clk;

  llc_excl_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_sfl(req_sfl), .req_dirty(req_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_sfl(rsp_sfl), .rsp_dirty(rsp_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr)
  );

  function automatic logic [31:0] mk(input int tag, input int set);
    return {tag[21:0], set[3:0], 6'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [31:0] a, input logic s, input logic d);
    @(negedge clk);
    req_kind = k; req_addr = a; req_sfl = s; req_dirty = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    c_rv = rsp_valid; c_rh = rsp_hit; c_rs = rsp_sfl; c_rd = rsp_dirty;
    c_wv = wb_valid;  c_wa = wb_addr;
    req_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic hit, input logic dirty, input string req);
    send(K_LOOK, a, 1'b0, 1'b0);
    chk(c_rv && c_rh == hit && c_rs == hit, req, {c_rv, c_rh, c_rs}, {1'b1, hit, hit});
    chk(c_rd == (hit & dirty), req, c_rd, hit & dirty);
  endtask

  task automatic inst(input logic [31:0] a, input logic s, input logic d,
                      input logic wbv, input logic [31:0] wba, input string req);
    send(K_INST, a, s, d);
    chk(c_wv == wbv, req, c_wv, wbv);
    if (wbv) chk(c_wa == wba, req, c_wa, wba);
    chk(!c_rv, req, c_rv, 0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R13", req_ready, 1);
    chk(rsp_valid == 1'b0 && wb_valid == 1'b0, "R13", {rsp_valid, wb_valid}, 0);
    look(mk(1, 0), 1'b0, 1'b0, "R13");
  endtask

  task automatic t_miss_fill();
    look(mk(5, 2), 1'b0, 1'b0, "R2");
    send(K_FILL, mk(5, 2), 1'b0, 1'b0);
    chk(c_rv && !c_rh && !c_rs, "R3", {c_rv, c_rh, c_rs}, 3'b100);
    look(mk(5, 2), 1'b0, 1'b0, "R3");
  endtask

  task automatic t_hit_dirty();
    inst(mk(7, 3), 1'b0, 1'b1, 1'b0, 0, "R8");
    look(mk(7, 3), 1'b1, 1'b1, "R8");
    look(mk(7, 3), 1'b0, 1'b0, "R1");
    inst(mk(8, 3), 1'b1, 1'b0, 1'b0, 0, "R8");
    look(mk(8, 3), 1'b1, 1'b0, "R1");
  endtask

  task automatic t_rrip();
    inst(mk(1, 4), 1'b0, 1'b1, 1'b0, 0, "R6");
    inst(mk(2, 4), 1'b1, 1'b0, 1'b0, 0, "R6");
    inst(mk(3, 4), 1'b0, 1'b0, 1'b0, 0, "R6");
    inst(mk(4, 4), 1'b1, 1'b1, 1'b0, 0, "R6");
    // all ways aged by one: way0 (dirty, origin 0) is the victim
    inst(mk(5, 4), 1'b1, 1'b0, 1'b1, mk(1, 4), "R9");
    // way2 already at 3 and clean: no writeback
    inst(mk(6, 4), 1'b0, 1'b0, 1'b0, 0, "R9");
    // origin-0 line at 2 is aged to 3 ahead of origin-1 lines
    inst(mk(9, 4), 1'b0, 1'b0, 1'b0, 0, "R7");
    look(mk(6, 4), 1'b0, 1'b0, "R4");
    look(mk(1, 4), 1'b0, 1'b0, "R7");
    look(mk(3, 4), 1'b0, 1'b0, "R7");
    look(mk(2, 4), 1'b1, 1'b0, "R5");
    look(mk(5, 4), 1'b1, 1'b0, "R5");
    look(mk(4, 4), 1'b1, 1'b1, "R5");
    look(mk(9, 4), 1'b1, 1'b0, "R4");
  endtask

  task automatic t_free_first();
    for (int i = 0; i < 4; i++) inst(mk(20 + i, 5), 1'b0, 1'b1, 1'b0, 0, "R6");
    look(mk(21, 5), 1'b1, 1'b1, "R6");
    inst(mk(30, 5), 1'b0, 1'b1, 1'b0, 0, "R6");
    look(mk(20, 5), 1'b1, 1'b1, "R6");
    look(mk(22, 5), 1'b1, 1'b1, "R6");
    look(mk(23, 5), 1'b1, 1'b1, "R6");
    look(mk(30, 5), 1'b1, 1'b1, "R6");
  endtask

  task automatic t_dup();
    inst(mk(40, 6), 1'b1, 1'b0, 1'b0, 0, "R12");
    inst(mk(40, 6), 1'b0, 1'b1, 1'b0, 0, "R12");
    look(mk(40, 6), 1'b1, 1'b1, "R12");
    look(mk(40, 6), 1'b0, 1'b0, "R12");
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 4; i++) inst(mk(10 + i, 7), 1'b0, 1'b1, 1'b0, 0, "R6");
    wb_ready = 1'b0;
    inst(mk(50, 7), 1'b0, 1'b1, 1'b1, mk(10, 7), "R9");
    @(negedge clk);
    req_kind = K_INST; req_addr = mk(51, 7); req_sfl = 1'b0; req_dirty = 1'b1; req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req_ready, "R10", req_ready, 0);
      chk(wb_valid && wb_addr == mk(10, 7), "R10", wb_addr, mk(10, 7));
    end
    wb_ready = 1'b1;
    @(posedge clk); #1;
    chk(wb_valid && wb_addr == mk(11, 7), "R11", wb_addr, mk(11, 7));
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk(!wb_valid, "R11", wb_valid, 0);
    look(mk(51, 7), 1'b1, 1'b1, "R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_fill();
    t_hit_dirty();
    t_rrip();
    t_free_first();
    t_dup();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule